// File: doc/BRIEF.md
# I2C Byte-Addressed Memory Target

This block is a target on a two-wire serial bus with a random-access byte memory behind it. The clock and data lines are oversampled by the local system clock, passed through synchronizers and watched for start conditions, stop conditions and clock edges. A select byte carries a fixed device-type nibble, three bits compared against strap pins and a direction bit. Up to eight of these targets can therefore share one pair of wires. A write select is followed by two word-address bytes and then any number of data bytes. A read select streams bytes out from the internal address counter for as long as the master acknowledges them.

Writes are committed in the same system cycle that the last bit of a data byte is taken. There is no busy period, so a new command can follow at once. A write-protect strap turns the whole array read-only, but the protocol is left unchanged. The block only ever pulls the data line low, through an open-drain enable output. The array is organised as rows of eight bytes. Its depth is set by the address-width parameter, from 9 to 15 bits, and 15 bits gives 32 KB.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset, and whenever no transfer is addressed to the block, `sda_oe_o` is 0 (the line is released).
- R2: A select byte is acknowledged only when its upper seven bits equal 1010 followed by `strap_i[2:0]`. Bit 0 of the select byte is the direction (1 = read). On a mismatch the block gives no acknowledge and does not drive the line for any further byte until the next start.
- R3: After a write select, two address bytes (high byte first) are each acknowledged. The word address is the lower ADDR_W bits of {high, low}, and higher bits are ignored.
- R4: With `wp_i` = 0, each data byte that follows the address is acknowledged and stored at the counter address.
- R5: With `wp_i` = 1, data bytes are still acknowledged, but the memory contents stay unchanged.
- R6: A repeated start followed by a read select returns the byte at the word address just loaded, most significant bit first.
- R7: A read select with no preceding address bytes reads from the current counter value (current-address read).
- R8: Each master acknowledge (data line low in the ninth clock) causes the next sequential byte to be sent. A master NACK (line high) releases the line and ends the transfer.
- R9: The address counter advances by one after every byte read or written, and wraps from the top address to 0.
- R10: A stop condition at any point returns the block to idle. A start condition at any point restarts select-byte reception. A data byte that is cut short by either is never written.
- R11: If the master acknowledges a byte it intended as the last one, the block starts driving the next byte's MSB in the following clock-low period.
- R12: A written byte can be read back immediately, with no wait between the write and the following command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| strap_i | input | 3 | Device-select strap bits |
| wp_i | input | 1 | Write-protect strap, high blocks all writes; tie low for normal use |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
A wrong protocol phase or bit count shows on the line within one bus clock. Either an acknowledge is missing or misplaced, or the target keeps driving when it should have released. A wrong address counter or a lost write stays hidden until a later read returns the wrong byte, so every write pattern is read back by random, current-address and sequential reads, including across the top-to-zero wrap. Write protection, aborts cut mid-byte and the acknowledged-last-byte case are each checked by a read-back or by observing the drive enable in the clock-low period that follows.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    // Protocol phase of the target engine
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_RXACK,
        PH_TX,
        PH_TXACK,
        PH_SKIP
    } phase_e;

    // Meaning of the byte currently being received
    typedef enum logic [1:0] {
        K_DEV,
        K_AHI,
        K_ALO,
        K_WDAT
    } kind_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
    localparam int         BYTE_W   = 8;

endpackage

// File: rtl/i2c_bus_sense.sv
module i2c_bus_sense #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_sy;
        logic [STAGES-1:0] sda_sy;
        logic              scl_p;
        logic              sda_p;
    } sense_t;

    sense_t s_q, s_d;

    assign scl_lvl = s_q.scl_sy[STAGES-1];
    assign sda_lvl = s_q.sda_sy[STAGES-1];

    always_comb begin
        s_d = s_q;
        s_d.scl_sy[0] = scl_i;
        s_d.sda_sy[0] = sda_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.scl_sy[i] = s_q.scl_sy[i-1];
            s_d.sda_sy[i] = s_q.sda_sy[i-1];
        end
        s_d.scl_p = scl_lvl;
        s_d.sda_p = sda_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    // Edges and bus conditions seen on the synchronized levels
    assign scl_rise  = scl_lvl & ~s_q.scl_p;
    assign scl_fall  = ~scl_lvl & s_q.scl_p;
    assign start_det = scl_lvl & s_q.scl_p & s_q.sda_p & ~sda_lvl;
    assign stop_det  = scl_lvl & s_q.scl_p & ~s_q.sda_p & sda_lvl;

endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
    parameter int ADDR_W    = 10,
    parameter int ROW_BYTES = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    localparam int COL_W = $clog2(ROW_BYTES);
    localparam int ROW_W = ADDR_W - COL_W;
    localparam int ROWS  = 1 << ROW_W;

    logic [7:0]       mem [ROWS][ROW_BYTES];
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;

    assign row = addr[ADDR_W-1:COL_W];
    assign col = addr[COL_W-1:0];

    // Registered read of the counter location, refreshed every cycle
    always_ff @(posedge clk) begin
        if (we) begin
            mem[row][col] <= wdata;
        end
        rdata <= mem[row][col];
    end

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
    import i2c_mem_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int SYNC_STAGES = 2,
    parameter int ROW_BYTES   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    output logic       sda_oe_o
);

    localparam int HI_W = ADDR_W - BYTE_W;

    typedef struct packed {
        phase_e            st;
        kind_e             kind;
        logic              rw;
        logic              mack;
        logic [3:0]        bits;
        logic [7:0]        sh;
        logic [HI_W-1:0]   ahi;
        logic [ADDR_W-1:0] addr;
        logic              oe;
    } ctl_t;

    ctl_t c_q, c_d;

    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       mem_we;
    logic [7:0] rdata;

    i2c_bus_sense #(
        .STAGES (SYNC_STAGES)
    ) u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_s),
        .sda_lvl   (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_mem_array #(
        .ADDR_W    (ADDR_W),
        .ROW_BYTES (ROW_BYTES)
    ) u_array (
        .clk   (clk),
        .we    (mem_we),
        .addr  (c_q.addr),
        .wdata (c_q.sh),
        .rdata (rdata)
    );

    always_comb begin
        c_d    = c_q;
        mem_we = 1'b0;
        if (start_det) begin
            c_d.st   = PH_RX;
            c_d.kind = K_DEV;
            c_d.bits = 4'd0;
            c_d.mack = 1'b0;
            c_d.oe   = 1'b0;
        end else if (stop_det) begin
            c_d.st = PH_IDLE;
            c_d.oe = 1'b0;
        end else begin
            unique case (c_q.st)
                PH_RX: begin
                    if (scl_rise && c_q.bits != 4'd8) begin
                        c_d.sh   = {c_q.sh[6:0], sda_s};
                        c_d.bits = c_q.bits + 4'd1;
                    end else if (scl_fall && c_q.bits == 4'd8) begin
                        c_d.st   = PH_RXACK;
                        c_d.oe   = 1'b1;
                        c_d.bits = 4'd0;
                        unique case (c_q.kind)
                            K_DEV: begin
                                if (c_q.sh[7:1] == {DEV_TYPE, strap_i}) begin
                                    c_d.rw = c_q.sh[0];
                                end else begin
                                    c_d.st = PH_SKIP;
                                    c_d.oe = 1'b0;
                                end
                            end
                            K_AHI: c_d.ahi = c_q.sh[HI_W-1:0];
                            K_ALO: c_d.addr = {c_q.ahi, c_q.sh};
                            K_WDAT: begin
                                mem_we   = !wp_i;
                                c_d.addr = c_q.addr + 1'b1;
                            end
                            default: c_d.st = PH_SKIP;
                        endcase
                    end
                end
                PH_RXACK: begin
                    if (scl_fall) begin
                        c_d.oe = 1'b0;
                        if (c_q.kind == K_DEV && c_q.rw) begin
                            c_d.st   = PH_TX;
                            c_d.sh   = {rdata[6:0], 1'b0};
                            c_d.oe   = ~rdata[7];
                            c_d.bits = 4'd1;
                        end else begin
                            c_d.st   = PH_RX;
                            c_d.bits = 4'd0;
                            unique case (c_q.kind)
                                K_DEV:   c_d.kind = K_AHI;
                                K_AHI:   c_d.kind = K_ALO;
                                default: c_d.kind = K_WDAT;
                            endcase
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (c_q.bits == 4'd8) begin
                            c_d.oe   = 1'b0;
                            c_d.st   = PH_TXACK;
                            c_d.mack = 1'b0;
                            c_d.addr = c_q.addr + 1'b1;
                        end else begin
                            c_d.oe   = ~c_q.sh[7];
                            c_d.sh   = {c_q.sh[6:0], 1'b0};
                            c_d.bits = c_q.bits + 4'd1;
                        end
                    end
                end
                PH_TXACK: begin
                    if (scl_rise) begin
                        if (sda_s) begin
                            c_d.st = PH_IDLE;
                            c_d.oe = 1'b0;
                        end else begin
                            c_d.mack = 1'b1;
                        end
                    end else if (scl_fall && c_q.mack) begin
                        c_d.st   = PH_TX;
                        c_d.sh   = {rdata[6:0], 1'b0};
                        c_d.oe   = ~rdata[7];
                        c_d.bits = 4'd1;
                        c_d.mack = 1'b0;
                    end
                end
                default: c_d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q      <= '0;
            c_q.st   <= PH_IDLE;
            c_q.kind <= K_DEV;
        end else begin
            c_q <= c_d;
        end
    end

    assign sda_oe_o = c_q.oe;

endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk
    import i2c_mem_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_lvl,
    input logic              start_det,
    input logic              stop_det,
    input logic              wp,
    input logic              mem_we,
    input logic              sda_oe,
    input phase_e            st,
    input kind_e             kind,
    input logic [3:0]        bits,
    input logic [ADDR_W-1:0] addr
);

    assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_IDLE || st == PH_SKIP) |-> !sda_oe);

    assert_drive_in_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);

    assert_no_write_protected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wp |-> !mem_we);

    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> st == PH_IDLE);

    assert_start_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st == PH_RX && kind == K_DEV && bits == 4'd0));

    assert_addr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> addr == ADDR_W'($past(addr) + 1'b1));

endmodule

bind i2c_mem_target i2c_mem_target_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .wp        (wp_i),
    .mem_we    (mem_we),
    .sda_oe    (sda_oe_o),
    .st        (c_q.st),
    .kind      (c_q.kind),
    .bits      (c_q.bits),
    .addr      (c_q.addr)
);

// File: tb/i2c_mem_target_tb.sv
`timescale 1ns/1ps
module i2c_mem_target_tb;

    localparam int         AW    = 10;
    localparam int         Q     = 8;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] SEL_W = 8'hAA;
    localparam logic [7:0] SEL_R = 8'hAB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_bus;

    assign sda_bus = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    i2c_mem_target #(.ADDR_W(AW)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .strap_i  (STRAP),
        .wp_i     (wp),
        .sda_oe_o (sda_oe)
    );

    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;
    int         oe_cnt = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] got;
    event       got_ev;

    always @(negedge clk) if (sda_oe) oe_cnt <= oe_cnt + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input bit b);
        sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic bit_in(output bit b);
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); b = sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic start_c;
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic stop_c;
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send(input logic [7:0] b, input bit exp_ack, input string tag);
        bit a;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(a);
        chk((a == 1'b0) == exp_ack, tag, "acknowledge", int'(!a), int'(exp_ack));
    endtask

    task automatic recv(input bit master_ack);
        bit         b;
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        got = v;
        ->got_ev;
        bit_out(!master_ack);
    endtask

    // Driver side of the scoreboard
    task automatic expect_byte(input logic [7:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string tag);
        send(SEL_W, 1'b1, "R2");
        send(hi, 1'b1, tag);
        send(lo, 1'b1, tag);
    endtask

    // Monitor side of the scoreboard
    initial begin
        forever begin
            @(got_ev);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8", "unexpected read byte", int'(got), 0);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(got === e, t, "read data", int'(got), int'(e));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int oe_before;
        wq(6);
        rst_n = 1'b1;
        wq(6);
        chk(sda_oe == 1'b0, "R1", "released after reset", int'(sda_oe), 0);

        // R4: sequential write of four bytes at 0x120
        start_c();
        set_addr(8'h01, 8'h20, "R3");
        send(8'h5A, 1'b1, "R4");
        send(8'h3C, 1'b1, "R4");
        send(8'h81, 1'b1, "R4");
        send(8'h96, 1'b1, "R4");
        stop_c();
        chk(sda_oe == 1'b0, "R1", "released when idle", int'(sda_oe), 0);

        // R6 random read, R8 sequential then NACK release
        start_c();
        set_addr(8'h01, 8'h20, "R3");
        start_c();
        send(SEL_R, 1'b1, "R6");
        expect_byte(8'h5A, "R6");
        recv(1'b1);
        expect_byte(8'h3C, "R8");
        recv(1'b0);
        wq(Q);
        chk(sda_oe == 1'b0, "R8", "released after NACK", int'(sda_oe), 0);
        stop_c();

        // R7 current-address read continues at 0x122
        start_c();
        send(SEL_R, 1'b1, "R7");
        expect_byte(8'h81, "R7");
        recv(1'b0);
        stop_c();

        // R9 wrap, R3 high bits ignored (0x7FFF maps to 0x3FF)
        start_c();
        set_addr(8'h7F, 8'hFF, "R3");
        send(8'h11, 1'b1, "R9");
        send(8'h22, 1'b1, "R9");
        stop_c();
        start_c();
        set_addr(8'h03, 8'hFF, "R3");
        start_c();
        send(SEL_R, 1'b1, "R9");
        expect_byte(8'h11, "R3");
        recv(1'b1);
        expect_byte(8'h22, "R9");
        recv(1'b0);
        stop_c();

        // R5 write protect: acknowledged but not stored
        wp = 1'b1;
        start_c();
        set_addr(8'h01, 8'h20, "R5");
        send(8'hEE, 1'b1, "R5");
        stop_c();
        wp = 1'b0;
        start_c();
        set_addr(8'h01, 8'h20, "R5");
        start_c();
        send(SEL_R, 1'b1, "R5");
        expect_byte(8'h5A, "R5");
        recv(1'b0);
        stop_c();

        // R2 strap mismatch: no acknowledge, no drive
        oe_before = oe_cnt;
        start_c();
        send(8'hA0, 1'b0, "R2");
        send(8'h00, 1'b0, "R2");
        send(8'hFF, 1'b0, "R2");
        chk(oe_cnt == oe_before, "R2", "no drive after mismatch", oe_cnt - oe_before, 0);
        stop_c();

        // R10 stop in the middle of a data byte: no write
        start_c();
        set_addr(8'h01, 8'h21, "R3");
        for (int i = 0; i < 4; i++) bit_out(1'b1);
        stop_c();
        start_c();
        set_addr(8'h01, 8'h21, "R10");
        start_c();
        send(SEL_R, 1'b1, "R10");
        expect_byte(8'h3C, "R10");
        recv(1'b0);
        stop_c();

        // R10 start in the middle of an address byte restarts select
        start_c();
        send(SEL_W, 1'b1, "R2");
        for (int i = 0; i < 3; i++) bit_out(1'b0);
        start_c();
        send(SEL_R, 1'b1, "R10");
        expect_byte(8'h81, "R10");
        recv(1'b0);
        stop_c();

        // R12 write then immediate read back via repeated starts
        start_c();
        set_addr(8'h02, 8'h00, "R3");
        send(8'h47, 1'b1, "R4");
        start_c();
        set_addr(8'h02, 8'h00, "R12");
        start_c();
        send(SEL_R, 1'b1, "R12");
        expect_byte(8'h47, "R12");
        recv(1'b0);
        stop_c();

        // R11 master acknowledges the intended last byte: target drives on
        start_c();
        set_addr(8'h01, 8'h20, "R3");
        start_c();
        send(SEL_R, 1'b1, "R11");
        expect_byte(8'h5A, "R11");
        recv(1'b1);
        chk(sda_oe == 1'b1, "R11", "drives next MSB after ack", int'(sda_oe), 1);
        expect_byte(8'h3C, "R11");
        recv(1'b0);
        stop_c();

        wq(20);
        chk(exp_q.size() == 0, "R8", "scoreboard drained", exp_q.size(), 0);
        chk(sda_oe == 1'b0, "R1", "released at end", int'(sda_oe), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule